// File: doc/BRIEF.md
# Tuner Synthesizer Two-Wire Register Slave

This block is the control port of a tuner frequency synthesizer. It listens on a two-wire serial bus (SCL clock, SDA data), sampled by the system clock, and answers a 7-bit device address. The address has a fixed five-bit prefix and two low bits taken from `addr_sel`. The low-bit pattern 01 is always answered as a general address. In a write, the data bytes travel in pairs. A pair whose first byte has MSB 0 carries the 15-bit divider value. A pair whose first byte has MSB 1 carries the control settings and then the band-switch outputs. Auto-increment lets one transfer program everything.

The divider is applied only when its second byte completes, so the loop never sees a half-written ratio. A read returns a status byte that packs a power-on flag, the lock flag, the current-switch flag and a 3-bit converter code. More status bytes follow for as long as the master acknowledges. SDA is never driven high: the block only raises an output enable that pulls the line low.

Top module: `tuner_twowire_slave`

## Requirements
- R1: A byte after START whose upper seven bits are 1100 0 followed by `addr_sel`, or 1100 0 followed by 01, is acknowledged by pulling SDA low during the 9th SCL pulse; bit 0 of that byte selects read (1) or write (0).
- R2: After any other address byte the block neither acknowledges nor drives SDA, and changes no register, until the next START.
- R3: In a write, every data byte is acknowledged during its 9th SCL pulse.
- R4: Data bytes form pairs counted from the first byte after the address. The first byte of each pair picks the pair type by its MSB: 0 means divider high byte, then divider low byte; 1 means control byte, then band byte.
- R5: The divider high byte (bits 6..0 = divider bits 14..8) is held in a stage. `divider_o` changes only when the low byte (divider bits 7..0) completes its 8th bit. A transfer that stops after the high byte leaves `divider_o` unchanged.
- R6: The control byte loads on its 8th bit: bit 6 to `cp_o`, bits 5..3 to `test_o`, bits 2..1 to `ratio_o`, bit 0 to `tune_off_o`. The band byte loads bits 3..0 to `band_o`, and its bits 7..4 are ignored.
- R7: A single transfer of address plus high, low, control and band bytes programs all outputs, and further bytes keep being accepted until STOP.
- R8: A read sends the status byte MSB first: {power-on flag, `lock_i`, `acps_i`, 1, 1, `adc_code`}. The status inputs are captured when the byte is loaded, and later changes during that byte do not affect it.
- R9: When the master acknowledges a status byte, a freshly captured status byte follows. When it does not, SDA is released.
- R10: The power-on flag reads 1 after reset and reads 0 once a read has ended with a master no-acknowledge.
- R11: After reset: `divider_o` = 0, `cp_o` = 1, `test_o` = 001, `ratio_o` = 00, `tune_off_o` = 0, `band_o` = 0000, `sda_oe` = 0.
- R12: `sda_oe` changes only while SCL is low, after an SCL falling edge or a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 2 | Low two address bits of this device |
| lock_i | input | 1 | Loop lock indication for status |
| acps_i | input | 1 | Current-switch flag for status |
| adc_code | input | 3 | Converter code for status |
| divider_o | output | 15 | Programmable divider ratio |
| cp_o | output | 1 | Charge-pump current select |
| test_o | output | 3 | Test and mode bits |
| ratio_o | output | 2 | Reference ratio select |
| tune_off_o | output | 1 | Tuning output disable |
| band_o | output | 4 | Band-switch driver enables |

## Verification
Capturing the status snapshot for the next byte and sampling the live status inputs can fall on the same edge, because the inputs may move while a byte is being shifted out. The bench changes lock, flag and converter inputs to fresh random values part-way through each status byte it reads. It expects the byte in progress to show the values present at its load. It expects the following acknowledged byte to show the new values. A second overlap arises when committing a divider low byte follows directly on a re-decoded pair start. Random write lengths up to five bytes produce that case, and a bench model of the pairing scores it.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [4:0] DEV_PREFIX = 5'b11000;
  localparam logic [1:0] GEN_SEL    = 2'b01;
  localparam int DIV_W   = 15;
  localparam int STAGE_W = DIV_W - 8;
  localparam int BAND_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sn,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [1:0]      rst_ch;
  logic [LAST:0]   scl_ch, sda_ch;
  logic            scl_q, sda_q;
  logic            scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ch <= 2'b00;
    else        rst_ch <= {rst_ch[0], 1'b1};
  end
  assign rst_sn = rst_ch[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[LAST-1:0], scl_i};
      sda_ch <= {sda_ch[LAST-1:0], sda_i};
      scl_q  <= scl_ch[LAST];
      sda_q  <= sda_ch[LAST];
    end
  end

  assign scl_s     = scl_ch[LAST];
  assign sda_lvl   = sda_ch[LAST];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_lvl,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic       wr_first,
  output logic [7:0] wr_byte,
  output logic       por_clr
);
  tw_state_e state, state_n;
  logic [3:0] cnt, cnt_n;
  logic [7:0] sh, sh_n;
  logic [6:0] tx, tx_n;
  logic       oe, oe_n;
  logic       first, first_n;
  logic       mack, mack_n;
  logic       addr_hit;

  assign addr_hit = (sh[7:1] == {DEV_PREFIX, addr_sel}) ||
                    (sh[7:1] == {DEV_PREFIX, GEN_SEL});
  assign wr_byte  = {sh[6:0], sda_lvl};
  assign wr_first = first;
  assign sda_oe   = oe;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sh_n    = sh;
    tx_n    = tx;
    oe_n    = oe;
    first_n = first;
    mack_n  = mack;
    wr_stb  = 1'b0;
    por_clr = 1'b0;
    if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh[6:0], sda_lvl};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            state_n = addr_hit ? ST_AACK : ST_SKIP;
            oe_n    = addr_hit;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_n = 4'd0;
            if (sh[0]) begin
              state_n = ST_RDAT;
              tx_n    = status[6:0];
              oe_n    = ~status[7];
            end else begin
              state_n = ST_WDAT;
              oe_n    = 1'b0;
              first_n = 1'b1;
            end
          end
        end
        ST_WDAT: begin
          if (scl_rise) begin
            sh_n   = {sh[6:0], sda_lvl};
            cnt_n  = cnt + 4'd1;
            wr_stb = (cnt == 4'd7);
          end else if (scl_fall && cnt == 4'd8) begin
            state_n = ST_WACK;
            oe_n    = 1'b1;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_n = ST_WDAT;
            oe_n    = 1'b0;
            cnt_n   = 4'd0;
            first_n = 1'b0;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              state_n = ST_RACK;
              oe_n    = 1'b0;
            end else begin
              tx_n = {tx[5:0], 1'b0};
              oe_n = ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n  = ~sda_lvl;
            por_clr = sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              state_n = ST_RDAT;
              cnt_n   = 4'd0;
              tx_n    = status[6:0];
              oe_n    = ~status[7];
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state <= ST_IDLE;
      cnt   <= 4'd0;
      sh    <= 8'd0;
      tx    <= 7'd0;
      oe    <= 1'b0;
      first <= 1'b0;
      mack  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      sh    <= sh_n;
      tx    <= tx_n;
      oe    <= oe_n;
      first <= first_n;
      mack  <= mack_n;
    end
  end

  // R12
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(oe) |-> $past(scl_fall || start_det || stop_det));
  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state == ST_SKIP) |-> !oe);
  // R3
  wack_drive_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state == ST_WACK) |-> oe);
endmodule

// File: rtl/tuner_regs.sv
module tuner_regs
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_stb,
  input  logic              wr_first,
  input  logic [7:0]        wr_byte,
  input  logic              por_clr,
  output logic [DIV_W-1:0]  divider,
  output logic              cp,
  output logic [2:0]        test,
  output logic [1:0]        ratio,
  output logic              tune_off,
  output logic [BAND_W-1:0] band,
  output logic              por
);
  logic               odd, odd_n, kind, kind_n, odd_eff;
  logic [STAGE_W-1:0] stage, stage_n;
  logic [DIV_W-1:0]   div_n;
  logic               cp_n, off_n, por_n;
  logic [2:0]         test_n;
  logic [1:0]         ratio_n;
  logic [BAND_W-1:0]  band_n;

  assign odd_eff = wr_first ? 1'b0 : odd;

  always_comb begin
    odd_n = odd; kind_n = kind; stage_n = stage; div_n = divider;
    cp_n = cp; test_n = test; ratio_n = ratio; off_n = tune_off;
    band_n = band;
    por_n = por & ~por_clr;
    if (wr_stb) begin
      if (!odd_eff) begin
        odd_n  = 1'b1;
        kind_n = wr_byte[7];
        if (!wr_byte[7]) begin
          stage_n = wr_byte[STAGE_W-1:0];
        end else begin
          cp_n    = wr_byte[6];
          test_n  = wr_byte[5:3];
          ratio_n = wr_byte[2:1];
          off_n   = wr_byte[0];
        end
      end else begin
        odd_n = 1'b0;
        if (!kind) div_n  = {stage, wr_byte};
        else       band_n = wr_byte[BAND_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      odd <= 1'b0; kind <= 1'b0; stage <= '0; divider <= '0;
      cp <= 1'b1; test <= 3'b001; ratio <= 2'b00; tune_off <= 1'b0;
      band <= '0; por <= 1'b1;
    end else begin
      odd <= odd_n; kind <= kind_n; stage <= stage_n; divider <= div_n;
      cp <= cp_n; test <= test_n; ratio <= ratio_n; tune_off <= off_n;
      band <= band_n; por <= por_n;
    end
  end

  // R5
  div_commit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(divider) |-> $past(wr_stb && !wr_first && odd && !kind));
  // R6
  band_commit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(band) |-> $past(wr_stb && !wr_first && odd && kind));
  // R10
  por_fall_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(por) |-> $past(por_clr));
  // R10
  por_norise_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !$rose(por));
endmodule

// File: rtl/tuner_twowire_slave.sv
module tuner_twowire_slave
  import tw_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  input  logic        lock_i,
  input  logic        acps_i,
  input  logic [2:0]  adc_code,
  output logic [14:0] divider_o,
  output logic        cp_o,
  output logic [2:0]  test_o,
  output logic [1:0]  ratio_o,
  output logic        tune_off_o,
  output logic [3:0]  band_o
);
  logic       rst_sn, scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic       wr_stb, wr_first, por_clr, por;
  logic [7:0] wr_byte, status;

  assign status = {por, lock_i, acps_i, 2'b11, adc_code};

  tw_sync #(.SYNC_DEPTH(SYNC_DEPTH)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_sn(rst_sn), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl));

  tw_engine i_engine (
    .clk(clk), .rst_sn(rst_sn), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
    .addr_sel(addr_sel), .status(status), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_first(wr_first), .wr_byte(wr_byte),
    .por_clr(por_clr));

  tuner_regs i_regs (
    .clk(clk), .rst_sn(rst_sn), .wr_stb(wr_stb), .wr_first(wr_first),
    .wr_byte(wr_byte), .por_clr(por_clr), .divider(divider_o), .cp(cp_o),
    .test(test_o), .ratio(ratio_o), .tune_off(tune_off_o), .band(band_o),
    .por(por));
endmodule

// File: tb/test_tuner_twowire_slave.sv
module test_tuner_twowire_slave;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic lock_i = 1'b0, acps_i = 1'b1;
  logic [2:0] adc_code = 3'd0;
  logic sda_oe, cp_o, tune_off_o;
  logic [14:0] divider_o;
  logic [2:0] test_o;
  logic [1:0] ratio_o;
  logic [3:0] band_o;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  tuner_twowire_slave i_tuner_twowire_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .acps_i(acps_i), .adc_code(adc_code),
    .divider_o(divider_o), .cp_o(cp_o), .test_o(test_o), .ratio_o(ratio_o),
    .tune_off_o(tune_off_o), .band_o(band_o));

  int n_cmp = 0, n_bad = 0, r12_viol = 0;
  logic done = 1'b0;

  // expected model
  logic [14:0] e_div; logic e_cp, e_off, e_por; logic [2:0] e_test;
  logic [1:0] e_ratio; logic [3:0] e_band;
  logic m_odd, m_kind; logic [6:0] m_stage;
  logic [7:0] wbuf [0:5];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R12 monitor: sda_oe must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== oe_prev) r12_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] status_of(input logic p);
    return {p, lock_i, acps_i, 2'b11, adc_code};
  endfunction

  task automatic model_byte(input logic [7:0] b, input bit first);
    logic o;
    o = first ? 1'b0 : m_odd;
    if (!o) begin
      m_odd = 1'b1; m_kind = b[7];
      if (!b[7]) m_stage = b[6:0];
      else begin e_cp = b[6]; e_test = b[5:3]; e_ratio = b[2:1]; e_off = b[0]; end
    end else begin
      m_odd = 1'b0;
      if (!m_kind) e_div = {m_stage, b}; else e_band = b[3:0];
    end
  endtask

  task automatic check_regs(input string tag);
    chk(divider_o == e_div, {"R5 divider ", tag}, divider_o, e_div);
    chk({cp_o, test_o, ratio_o, tune_off_o} == {e_cp, e_test, e_ratio, e_off},
        {"R6 control ", tag}, {cp_o, test_o, ratio_o, tune_off_o},
        {e_cp, e_test, e_ratio, e_off});
    chk(band_o == e_band, {"R6 band ", tag}, band_o, e_band);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(Q);
    scl = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl = 1'b1; hold(2*Q);
      scl = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    ack = ~sda_line; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic rx_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl = 1'b1; hold(Q);
      b[i] = sda_line; hold(Q);
      scl = 1'b0;
    end
    sda_m = ~mack; hold(Q);
    scl = 1'b1; hold(2*Q);
    scl = 1'b0; hold(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input bit hit, input string tag);
    logic ack;
    bus_start;
    tx_byte({a, 1'b0}, ack);
    chk(ack == hit, hit ? "R1 address ack" : "R2 no address ack", ack, hit);
    for (int k = 0; k < n; k++) begin
      tx_byte(wbuf[k], ack);
      if (hit) begin
        chk(ack == 1'b1, "R3 data ack", ack, 1);
        model_byte(wbuf[k], k == 0);
      end else begin
        chk(ack == 1'b0, "R2 data ignored", ack, 0);
      end
    end
    bus_stop;
    check_regs(tag);
  endtask

  task automatic do_read(input logic [6:0] a, input int n);
    logic ack; logic [7:0] b, e;
    bus_start;
    tx_byte({a, 1'b1}, ack);
    chk(ack == 1'b1, "R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      e = status_of(e_por);
      fork
        rx_byte(k < n - 1, b);
        begin
          hold(3*Q);
          lock_i = 1'($urandom); acps_i = 1'($urandom); adc_code = 3'($urandom);
        end
      join
      chk(b == e, k == 0 ? "R8 status byte" : "R9 next status byte", b, e);
    end
    e_por = 1'b0;
    hold(Q);
    chk(sda_oe == 1'b0, "R9 release after nack", sda_oe, 0);
    bus_stop;
  endtask

  function automatic logic [6:0] pick_addr(input int kind, input logic [1:0] sel);
    logic [1:0] w;
    if (kind == 0) return {5'b11000, sel};
    if (kind == 1) return {5'b11000, 2'b01};
    w = (sel == 2'b00) ? 2'b10 : 2'b00;
    return {5'b11000, w};
  endfunction

  initial begin
    void'($urandom(32'h5eed_7a11));
    e_div = '0; e_cp = 1'b1; e_test = 3'b001; e_ratio = 2'b00; e_off = 1'b0;
    e_band = '0; e_por = 1'b1; m_odd = 1'b0; m_kind = 1'b0; m_stage = '0;
    hold(5); rst_n = 1'b1; hold(10);

    // R11 reset state
    chk({divider_o, cp_o, test_o, ratio_o, tune_off_o, band_o, sda_oe} ==
        {15'd0, 1'b1, 3'b001, 2'b00, 1'b0, 4'd0, 1'b0},
        "R11 reset outputs", {divider_o, cp_o, test_o, ratio_o, tune_off_o, band_o},
        {15'd0, 1'b1, 3'b001, 2'b00, 1'b0, 4'd0});

    // R5: high byte alone leaves divider unchanged
    wbuf[0] = 8'h55;
    do_write(7'b1100000, 1, 1'b1, "R5 high byte only");

    // R7: full programming in one transfer
    wbuf[0] = 8'h2A; wbuf[1] = 8'hC3; wbuf[2] = 8'hB5; wbuf[3] = 8'hF9;
    do_write(7'b1100000, 4, 1'b1, "R7 full transfer");

    // R4: control pair first, then divider pair
    wbuf[0] = 8'h8E; wbuf[1] = 8'h06; wbuf[2] = 8'h11; wbuf[3] = 8'h22;
    do_write(7'b1100001, 4, 1'b1, "R4 control first");

    // R10 / R9: first read shows power-on flag, two bytes
    do_read(7'b1100001, 2);
    do_read(7'b1100000, 1);

    // R2: foreign address changes nothing
    wbuf[0] = 8'h7F; wbuf[1] = 8'hFF;
    do_write(7'b1100011, 2, 1'b0, "R2 foreign address");

    for (int it = 0; it < 28; it++) begin
      int kind, n;
      logic [1:0] sel;
      case ($urandom_range(0, 2))
        0: sel = 2'b00;
        1: sel = 2'b10;
        default: sel = 2'b11;
      endcase
      addr_sel = sel;
      kind = $urandom_range(0, 2);
      lock_i = 1'($urandom); acps_i = 1'($urandom); adc_code = 3'($urandom);
      if ($urandom_range(0, 3) == 0 && kind != 2) begin
        do_read(pick_addr(kind, sel), $urandom_range(1, 3));
      end else begin
        n = $urandom_range(1, 5);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        do_write(pick_addr(kind, sel), n, kind != 2, "random write");
      end
    end

    chk(r12_viol == 0, "R12 SDA enable stable while SCL high", r12_viol, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule